// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches one bank of general-purpose pins, grouped into ports of eight pins each, and turns pin activity into a single interrupt line for the bank. Software picks a trigger condition for each pin: rising edge, falling edge, any edge, high level or low level. A pin whose condition is met sets its status bit. Each status bit stays set until software clears it. Status is recorded whether or not the pin is enabled. A per-pin enable decides whether a set status bit reaches the bank interrupt.

Software reaches the registers through a simple write/read bus with a combinational read path. Each port has four words: status, enable, trigger type and clear. Status, enable and trigger type also have a masked-write alias, so a single pin can be changed without a read-modify-write. The pin inputs are expected to be synchronized to the clock already.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, the status, enable and trigger-type words of every port read zero and `irq_o` is low.
- R2: Trigger code 0x000101 in a pin's position (polarity bit p, edge bit 8+p) sets status bit p on the first clock edge after the pin goes from 0 to 1, and a 1-to-0 change does not set it.
- R3: Trigger code 0x000100 (edge bit only) sets status bit p only after a 1-to-0 change of the pin.
- R4: Trigger code 0x010100 (edge bit plus any-edge bit 16+p) sets status bit p after a change of the pin in either direction.
- R5: Trigger code 0x000001 sets status bit p on every clock edge while the pin is high, even on the edge that performs a clear. Code 0x000000 does the same while the pin is low.
- R6: A write to the clear word (0x70) clears each status bit whose data bit is 1. Bits written as 0 keep their value.
- R7: When a clear of bit p and a new qualifying edge on pin p fall in the same cycle, status bit p remains set.
- R8: `irq_o` is the OR, over all ports and pins, of status AND enable. Status is latched for disabled pins as well.
- R9: Adding 0x800 to the status, enable or trigger-type word gives a masked write. For status and enable, data bits [15:8] select pins and bits [7:0] give their new values. For trigger type, bits [31:24] select pins and bits [23:0] give the new type bits. Unselected bits are unchanged.
- R10: Port k's words sit at the port-0 offset plus 4*k (status 0x40, enable 0x50, type 0x60, clear 0x70). Pin k*8+p of `pin_i` belongs to port k, bit p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PORTS*PINS | Synchronized pin levels, port-major |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench builds the block with its defaults: four ports of eight pins and a 12-bit address. This full-width setup makes every port offset and the masked alias at 0x800 reachable, and puts the 24-bit trigger word with its separate mask byte to work. Each port is given a different trigger mode, so rising, falling, any-edge and both level modes run side by side in one bank. This also shows that a clear on one port leaves the others untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int BUS_W = 32;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_ENB,
      SEL_TYPE,
      SEL_CLR
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e         sel;
      logic             masked;
      logic [BUS_W-1:0] data;
   } reg_wr_t;

   localparam logic [3:0] NIB_STAT = 4'h4;
   localparam logic [3:0] NIB_ENB  = 4'h5;
   localparam logic [3:0] NIB_TYPE = 4'h6;
   localparam logic [3:0] NIB_CLR  = 4'h7;
endpackage

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig (
   input  logic cur,
   input  logic prev,
   input  logic pol,
   input  logic edge_mode,
   input  logic any_edge,
   output logic hit
);
   always_comb begin
      if (!edge_mode)    hit = (cur == pol);
      else if (any_edge) hit = cur ^ prev;
      else if (pol)      hit = cur & ~prev;
      else               hit = ~cur & prev;
   end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PINS-1:0]   pin_i,
   input  reg_wr_t           wr,
   output logic [PINS-1:0]   stat_o,
   output logic [PINS-1:0]   enb_o,
   output logic [3*PINS-1:0] typ_o
);
   localparam int TYP_W = 3 * PINS;

   if (4 * PINS > BUS_W) begin : g_chk
      $error("gpio_irq_port: PINS too wide for bus");
   end

   logic [PINS-1:0]  stat, enb, pin_q, hit, stat_base;
   logic [TYP_W-1:0] typ;
   logic [PINS-1:0]  wmask, wval, tmask;
   logic [TYP_W-1:0] tmask3;

   assign wval   = wr.data[PINS-1:0];
   assign wmask  = wr.data[2*PINS-1:PINS];
   assign tmask  = wr.data[3*PINS +: PINS];
   assign tmask3 = {tmask, tmask, tmask};

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      gpio_irq_trig u_trig (
         .cur       (pin_i[i]),
         .prev      (pin_q[i]),
         .pol       (typ[i]),
         .edge_mode (typ[PINS + i]),
         .any_edge  (typ[2*PINS + i]),
         .hit       (hit[i])
      );

      AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         (typ[PINS+i] && typ[i] && !typ[2*PINS+i] && pin_i[i] && !pin_q[i]) |=> stat[i]); // R2
      AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!typ[PINS+i] && (pin_i[i] == typ[i])) |=> stat[i]); // R5
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr.sel == SEL_CLR && wr.data[i] && !hit[i]) |=> !stat[i]); // R6
      AST_CLR_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (wr.sel == SEL_CLR && hit[i]) |=> stat[i]); // R7
   end

   always_comb begin
      stat_base = stat;
      case (wr.sel)
         SEL_STAT: stat_base = wr.masked ? ((stat & ~wmask) | (wval & wmask)) : wval;
         SEL_CLR:  stat_base = stat & ~wval;
         default:  stat_base = stat;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat  <= '0;
         enb   <= '0;
         typ   <= '0;
         pin_q <= '0;
      end else begin
         pin_q <= pin_i;
         stat  <= stat_base | hit;
         if (wr.sel == SEL_ENB)
            enb <= wr.masked ? ((enb & ~wmask) | (wval & wmask)) : wval;
         if (wr.sel == SEL_TYPE)
            typ <= wr.masked ? ((typ & ~tmask3) | (wr.data[TYP_W-1:0] & tmask3))
                             : wr.data[TYP_W-1:0];
      end
   end

   assign stat_o = stat;
   assign enb_o  = enb;
   assign typ_o  = typ;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int PORTS  = 4,
   parameter int PINS   = 8,
   parameter int ADDR_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PORTS*PINS-1:0] pin_i,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   output logic                  irq_o
);
   localparam int PIN_W = PORTS * PINS;
   localparam int TYP_W = 3 * PINS;

   if (PORTS < 1 || PORTS > 4) begin : g_chk_ports
      $error("gpio_irq_bank: PORTS must be 1..4");
   end
   if (PINS != 8) begin : g_chk_pins
      $error("gpio_irq_bank: register layout needs PINS == 8");
   end
   if (ADDR_W < 12) begin : g_chk_addr
      $error("gpio_irq_bank: ADDR_W must be at least 12");
   end

   logic       in_range, alias_hit;
   logic [1:0] pidx;
   reg_sel_e   sel;

   assign in_range  = ((bus_addr >> 12) == '0) && (bus_addr[10:8] == 3'b000)
                      && (bus_addr[1:0] == 2'b00);
   assign alias_hit = bus_addr[11];
   assign pidx      = bus_addr[3:2];

   always_comb begin
      sel = SEL_NONE;
      if (in_range) begin
         case (bus_addr[7:4])
            NIB_STAT: sel = SEL_STAT;
            NIB_ENB:  sel = SEL_ENB;
            NIB_TYPE: sel = SEL_TYPE;
            NIB_CLR:  sel = alias_hit ? SEL_NONE : SEL_CLR;
            default:  sel = SEL_NONE;
         endcase
      end
   end

   logic [PINS-1:0]  stat_a [PORTS];
   logic [PINS-1:0]  enb_a  [PORTS];
   logic [TYP_W-1:0] typ_a  [PORTS];
   logic [PIN_W-1:0] enb_flat, act_flat;

   for (genvar k = 0; k < PORTS; k++) begin : g_port
      reg_wr_t wr_k;
      always_comb begin
         wr_k.sel    = (bus_wr && pidx == 2'(k)) ? sel : SEL_NONE;
         wr_k.masked = alias_hit;
         wr_k.data   = bus_wdata;
      end

      gpio_irq_port #(.PINS(PINS)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[k*PINS +: PINS]),
         .wr     (wr_k),
         .stat_o (stat_a[k]),
         .enb_o  (enb_a[k]),
         .typ_o  (typ_a[k])
      );

      assign enb_flat[k*PINS +: PINS] = enb_a[k];
      assign act_flat[k*PINS +: PINS] = stat_a[k] & enb_a[k];
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < PORTS; k++) begin
         if (pidx == 2'(k)) begin
            case (sel)
               SEL_STAT: bus_rdata = 32'(stat_a[k]);
               SEL_ENB:  bus_rdata = 32'(enb_a[k]);
               SEL_TYPE: bus_rdata = 32'(typ_a[k]);
               default:  bus_rdata = '0;
            endcase
         end
      end
   end

   assign irq_o = |act_flat;

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (enb_flat == '0) |-> !irq_o); // R8
   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |-> !irq_o); // R1
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_bank #(.PORTS(4), .PINS(8), .ADDR_W(12)) dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   function automatic logic [11:0] a_stat(int k); return 12'h040 + 12'(4*k); endfunction
   function automatic logic [11:0] a_enb (int k); return 12'h050 + 12'(4*k); endfunction
   function automatic logic [11:0] a_typ (int k); return 12'h060 + 12'(4*k); endfunction
   function automatic logic [11:0] a_clr (int k); return 12'h070 + 12'(4*k); endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bwrite(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_pin(int idx, logic v);
      @(negedge clk);
      pins[idx] = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int k = 0; k < 4; k++) begin
         bus_addr = a_stat(k); #1 check("R1", "status in reset", bus_rdata, 0);
         bus_addr = a_enb(k);  #1 check("R1", "enable in reset", bus_rdata, 0);
         bus_addr = a_typ(k);  #1 check("R1", "type in reset", bus_rdata, 0);
      end
      check("R1", "irq in reset", 32'(irq_o), 0);
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < 4; k++) bwrite(a_typ(k), 32'h0000FF);
      for (int k = 0; k < 4; k++) bwrite(a_clr(k), 32'hFF);
      for (int k = 0; k < 4; k++) begin
         bread(a_stat(k), d); check("R6", "status after initial clear", d, 0);
      end
      for (int k = 0; k < 4; k++) bwrite(a_enb(k), 32'(k + 1));
      for (int k = 0; k < 4; k++) begin
         bread(a_enb(k), d); check("R10", "per-port enable word", d, 32'(k + 1));
      end
      for (int k = 0; k < 4; k++) bwrite(a_enb(k), 0);
   endtask

   task automatic t_rising();
      logic [31:0] d;
      bwrite(a_typ(0), 32'h00FFFF);
      bwrite(a_clr(0), 32'hFF);
      set_pin(2, 1'b1);
      bread(a_stat(0), d); check("R2", "rising edge latched", d, 32'h04);
      bwrite(a_clr(0), 32'h04);
      set_pin(2, 1'b0);
      bread(a_stat(0), d); check("R2", "falling ignored in rising mode", d, 0);
   endtask

   task automatic t_falling();
      logic [31:0] d;
      bwrite(a_typ(1), 32'h00FF00);
      bwrite(a_clr(1), 32'hFF);
      set_pin(13, 1'b1);
      bread(a_stat(1), d); check("R3", "rise ignored in falling mode", d, 0);
      set_pin(13, 1'b0);
      bread(a_stat(1), d); check("R3", "falling edge latched", d, 32'h20);
   endtask

   task automatic t_both();
      logic [31:0] d;
      bwrite(a_typ(2), 32'hFFFF00);
      bwrite(a_clr(2), 32'hFF);
      set_pin(16, 1'b1);
      bread(a_stat(2), d); check("R4", "any-edge on rise", d, 32'h01);
      bwrite(a_clr(2), 32'h01);
      bread(a_stat(2), d); check("R6", "any-edge bit cleared", d, 0);
      set_pin(16, 1'b0);
      bread(a_stat(2), d); check("R4", "any-edge on fall", d, 32'h01);
      bread(a_stat(1), d); check("R10", "port 1 untouched by port 2", d, 32'h20);
   endtask

   task automatic t_level();
      logic [31:0] d;
      set_pin(31, 1'b1);
      bread(a_stat(3), d); check("R5", "level high sets", d, 32'h80);
      bwrite(a_clr(3), 32'h80);
      bread(a_stat(3), d); check("R5", "level high re-sets after clear", d, 32'h80);
      set_pin(31, 1'b0);
      bwrite(a_clr(3), 32'h80);
      bread(a_stat(3), d); check("R5", "level released clears", d, 0);
      bwrite(a_typ(3), 32'h000000);
      bread(a_stat(3), d); check("R5", "level low sets all low pins", d, 32'hFF);
      bwrite(a_typ(3), 32'h0000FF);
      bwrite(a_clr(3), 32'hFF);
      bread(a_stat(3), d); check("R5", "level high with low pins stays clear", d, 0);
   endtask

   task automatic t_clear_zero();
      logic [31:0] d;
      set_pin(2, 1'b1);
      bwrite(a_clr(0), 32'h00);
      bread(a_stat(0), d); check("R6", "zero clear has no effect", d, 32'h04);
      bwrite(a_clr(0), 32'h04);
      bread(a_stat(0), d); check("R6", "one clears bit", d, 0);
      set_pin(2, 1'b0);
   endtask

   task automatic t_clear_race();
      logic [31:0] d;
      set_pin(3, 1'b1);
      set_pin(3, 1'b0);
      bread(a_stat(0), d); check("R2", "edge kept after low", d, 32'h08);
      @(negedge clk);
      pins[3] = 1'b1;
      bus_wr = 1'b1; bus_addr = a_clr(0); bus_wdata = 32'h08;
      @(negedge clk);
      bus_wr = 1'b0;
      bread(a_stat(0), d); check("R7", "edge wins over same-cycle clear", d, 32'h08);
      bwrite(a_clr(0), 32'h08);
      pins[3] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      bread(a_stat(1), d); check("R8", "status latched while disabled", d, 32'h20);
      check("R8", "irq low while disabled", 32'(irq_o), 0);
      bwrite(a_enb(1), 32'h20);
      #1 check("R8", "irq high when enabled", 32'(irq_o), 1);
      bwrite(a_enb(1), 32'h00);
      #1 check("R8", "irq low after disable", 32'(irq_o), 0);
      bread(a_stat(1), d); check("R8", "status kept after disable", d, 32'h20);
   endtask

   task automatic t_alias();
      logic [31:0] d;
      bwrite(a_enb(1), 32'h80);
      bwrite(12'h800 + a_enb(1), 32'h0301);
      bread(a_enb(1), d); check("R9", "masked enable", d, 32'h81);
      bwrite(12'h800 + a_typ(0), 32'h01010100);
      bread(a_typ(0), d); check("R9", "masked type", d, 32'h01FFFE);
      bwrite(12'h800 + a_stat(1), 32'h2000);
      bread(a_stat(1), d); check("R9", "masked status clear", d, 0);
      bwrite(12'h800 + a_stat(2), 32'h0202);
      bread(a_stat(2), d); check("R9", "masked status set", d, 32'h03);
   endtask

   initial begin
      t_reset();
      t_rising();
      t_falling();
      t_both();
      t_level();
      t_clear_zero();
      t_clear_race();
      t_irq();
      t_alias();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule